// File: doc/BRIEF.md
# Line Charge-Share Pulse Timer

This block generates the enable for the column charge-share switches of a panel driver at the start of each display line. The line-load strobe comes from another clock domain. It is brought into the data-clock domain through a two-stage synchronizer. Its falling edge marks the start of a line. At that edge the block samples the line polarity and compares it with the polarity held from the line before. Sharing happens only when the polarity has flipped. Under n-line inversion, lines that keep their polarity therefore draw no sharing pulse.

A two-bit length select picks the pulse length: 16, 32, 64 or 128 data clocks. The block samples the select once, when an interval starts. The share-enable output comes straight from a flip-flop, so it cannot glitch. A busy flag covers the interval and the one clock in which a detected strobe edge is waiting for its polarity decision. The interface is plain control wiring. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `line_share_timer`

## Requirements
- R1: While reset is low, and afterwards until a strobe falling edge has been processed, share_en and busy are low.
- R2: Suppose load_strobe is low at a rising clock edge, after being high at the edge before. share_en then goes high right after the third rising edge that sees it low: two edges for synchronization and one for the decision.
- R3: share_en stays high for exactly 16 << len_sel clocks: code 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128. len_sel[1] is the upper code bit. The all-low default code gives 16.
- R4: If polarity sampled at a strobe falling edge equals the value sampled at the previous falling edge, no pulse is produced.
- R5: The first strobe falling edge after reset always produces a pulse, whatever the polarity.
- R6: A rising edge of load_strobe never starts or extends a pulse.
- R7: len_sel is sampled when an interval starts. A change during the interval does not alter its length.
- R8: A falling edge that arrives during an active pulse and whose polarity differs from the previous line restarts the count from zero. The pulse then ends 16 << len_sel clocks after the restart. A falling edge that arrives during a pulse with unchanged polarity leaves that pulse's length untouched.
- R9: busy is high whenever share_en is high. It is also high for the single clock in which a synchronized falling edge awaits its polarity decision. A sharing line therefore shows busy for length+1 clocks, starting one clock before share_en. A suppressed line shows busy for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_strobe | input | 1 | Line-load strobe, asynchronous; falling edge starts a line |
| polarity | input | 1 | Line polarity, sampled at each detected falling edge |
| len_sel | input | 2 | Pulse-length code, bit 1 upper |
| share_en | output | 1 | Registered charge-share enable |
| busy | output | 1 | Interval active or strobe edge awaiting decision |

## Verification
A stale polarity register shows up at the very next line: a pulse appears on a line that keeps its polarity, or a pulse is missing on a line that flips. Either is visible three clocks after the strobe falls. A counter or length latch that is off by even one clock shows up in the count of high cycles on share_en, which the bench measures for every code. A synchronizer stage that is missing or extra moves the rising edge of busy and share_en by one clock from the expected third edge. A restart that fails to clear the count cuts the stretched pulse short within 16 to 128 clocks.

// File: rtl/share_pkg.sv
package share_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_evt_t;

  function automatic int unsigned span_of(input int unsigned base, input int unsigned code);
    return base << code;
  endfunction
endpackage

// File: rtl/share_sync.sv
module share_sync
  import share_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        async_in,
  output strobe_evt_t evt
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  always_comb begin
    evt.fall = prev_q & ~chain_q[STAGES-1];
    evt.rise = ~prev_q & chain_q[STAGES-1];
  end
endmodule

// File: rtl/share_polarity_gate.sv
module share_polarity_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic pol,
  output logic start
);
  logic first_q;
  logic pol_q;

  assign start = fall & (first_q | (pol != pol_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      pol_q   <= 1'b0;
    end else if (fall) begin
      first_q <= 1'b0;
      pol_q   <= pol;
    end
  end
endmodule

// File: rtl/share_interval_timer.sv
module share_interval_timer
  import share_pkg::*;
#(
  parameter int BASE_LEN = 16,
  parameter int SEL_W    = 2,
  localparam int MAX_LEN = BASE_LEN << ((1 << SEL_W) - 1),
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = CNT_W'(span_of(BASE_LEN, 32'(sel)) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
      last_q <= last_val;
    end else if (active) begin
      if (cnt_q == last_q) active <= 1'b0;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_share_timer.sv
module line_share_timer
  import share_pkg::*;
#(
  parameter int BASE_LEN    = 16,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_strobe,
  input  logic             polarity,
  input  logic [SEL_W-1:0] len_sel,
  output logic             share_en,
  output logic             busy
);
  strobe_evt_t evt;
  logic        fall_evt;
  logic        rise_evt;
  logic        start_evt;
  logic        active;

  share_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (load_strobe),
    .evt      (evt)
  );

  assign fall_evt = evt.fall;
  assign rise_evt = evt.rise;

  share_polarity_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .fall  (fall_evt),
    .pol   (polarity),
    .start (start_evt)
  );

  share_interval_timer #(.BASE_LEN(BASE_LEN), .SEL_W(SEL_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_evt),
    .sel    (len_sel),
    .active (active)
  );

  assign share_en = active;
  assign busy     = active | fall_evt;
endmodule

// File: rtl/line_share_timer_checker.sv
module line_share_timer_checker #(
  parameter int BASE_LEN = 16,
  parameter int SEL_W    = 2,
  localparam int RUN_W   = $clog2(BASE_LEN << ((1 << SEL_W) - 1)) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall,
  input logic             rise,
  input logic             start,
  input logic [SEL_W-1:0] sel,
  input logic             share_en,
  input logic             busy
);
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      exp_q <= '0;
    end else if (start) begin
      run_q <= '0;
      exp_q <= RUN_W'(BASE_LEN << sel);
    end else if (share_en) begin
      run_q <= run_q + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!share_en && !busy));
  a_r2_rise_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(share_en) |-> $past(start));
  a_r3_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(share_en) |-> (run_q == exp_q));
  a_r4_same_pol_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !start && !share_en) |=> !share_en);
  a_r6_rise_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !share_en) |=> !share_en);
  a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    share_en |-> busy);
endmodule

bind line_share_timer line_share_timer_checker #(.BASE_LEN(BASE_LEN), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fall     (fall_evt),
  .rise     (rise_evt),
  .start    (start_evt),
  .sel      (len_sel),
  .share_en (share_en),
  .busy     (busy)
);

// File: tb/sim_line_share_timer.sv
module sim_line_share_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_strobe = 1'b0;
  logic       polarity = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic       share_en;
  logic       busy;
  int         n_total = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10ns clk = ~clk;

  line_share_timer u0 (
    .clk(clk), .rst_n(rst_n), .load_strobe(load_strobe), .polarity(polarity),
    .len_sel(len_sel), .share_en(share_en), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives one falling strobe edge at a negedge and samples every following negedge.
  task automatic run_line(input logic pol, input logic [1:0] sel, input int n,
                          input int re_hi, input int re_lo, input logic pol2,
                          input int sel_at, input logic [1:0] sel2,
                          output int first, output int highs,
                          output int busys, output int first_busy);
    @(negedge clk);
    polarity = pol; len_sel = sel; load_strobe = 1'b0;
    first = -1; highs = 0; busys = 0; first_busy = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (share_en) begin highs++; if (first < 0) first = i; end
      if (busy) begin busys++; if (first_busy < 0) first_busy = i; end
      if (i == re_hi) load_strobe = 1'b1;
      if (i == re_lo) begin load_strobe = 1'b0; polarity = pol2; end
      if (i == sel_at) len_sel = sel2;
    end
    load_strobe = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "share_en in reset", int'(share_en), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1; load_strobe = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "share_en idle after reset", int'(share_en), 0);
    chk("R1", "busy idle after reset", int'(busy), 0);
  endtask

  task automatic t_first_line();
    int f, h, b, fb;
    run_line(1'b0, 2'd0, 40, -1, -1, 1'b0, -1, 2'd0, f, h, b, fb);
    chk("R5", "first line pulse length", h, 16);
    chk("R2", "first line start cycle", f, 3);
  endtask

  task automatic t_lengths();
    int f, h, b, fb;
    for (int c = 0; c < 4; c++) begin
      run_line(c[0] ? 1'b0 : 1'b1, 2'(c), 140, -1, -1, 1'b0, -1, 2'd0, f, h, b, fb);
      chk("R3", $sformatf("length code %0d", c), h, 16 << c);
      chk("R2", $sformatf("start cycle code %0d", c), f, 3);
      chk("R9", $sformatf("busy span code %0d", c), b, (16 << c) + 1);
      chk("R9", $sformatf("busy lead code %0d", c), fb, 2);
    end
  endtask

  task automatic t_same_pol();
    int f, h, b, fb;
    run_line(1'b0, 2'd1, 50, -1, -1, 1'b0, -1, 2'd0, f, h, b, fb);
    chk("R4", "unchanged polarity pulse", h, 0);
    chk("R9", "suppressed line busy span", b, 1);
    chk("R9", "suppressed line busy cycle", fb, 2);
  endtask

  task automatic t_two_line_inversion();
    int f, h, b, fb;
    logic pats [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    for (int k = 0; k < 4; k++) begin
      run_line(pats[k], 2'd0, 30, -1, -1, 1'b0, -1, 2'd0, f, h, b, fb);
      chk("R4", $sformatf("two-line inversion line %0d", k), h, (k % 2 == 0) ? 16 : 0);
    end
  endtask

  task automatic t_rise_only();
    int f, h, b, fb;
    // Suppressed fall, then a rising edge inside the window: nothing may start.
    run_line(1'b0, 2'd0, 20, 6, -1, 1'b0, -1, 2'd0, f, h, b, fb);
    chk("R6", "rising edge pulse count", h, 0);
    chk("R6", "rising edge busy count", b, 1);
  endtask

  task automatic t_sel_mid();
    int f, h, b, fb;
    run_line(1'b1, 2'd0, 40, -1, -1, 1'b0, 5, 2'd3, f, h, b, fb);
    chk("R7", "length with mid-interval select change", h, 16);
    run_line(1'b0, len_sel, 140, -1, -1, 1'b0, -1, 2'd0, f, h, b, fb);
    chk("R7", "new select on next line", h, 128);
  endtask

  task automatic t_restart();
    int f, h, b, fb;
    run_line(1'b1, 2'd1, 80, 8, 12, 1'b0, -1, 2'd0, f, h, b, fb);
    chk("R8", "restarted pulse length", h, 12 + 32);
    chk("R8", "restarted pulse start", f, 3);
    run_line(1'b1, 2'd1, 80, 8, 12, 1'b1, -1, 2'd0, f, h, b, fb);
    chk("R8", "same-polarity edge during pulse", h, 32);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    t_reset();
    t_first_line();
    t_lengths();
    t_same_pol();
    t_two_line_inversion();
    t_rise_only();
    t_sel_mid();
    t_restart();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule